// File: doc/BRIEF.md
# Segmented Cache Test Victim Pointer Controller

This block gives a debug host line-by-line access to a segmented cache's tag store (CAM) and data store (RAM). Each segment keeps a replacement pointer that selects the line for every tag or data test access. The host first loads a segment's pointer with one of two write commands. It can then issue back-to-back accesses that walk the segment without reloading the pointer, because the pointer steps forward by itself after each access.

The write command that loaded the pointer also sets when it steps. The lockdown-base form makes it advance after tag and data accesses alike. The plain form makes it advance after tag accesses only. Every tag read copies the segment's current pointer into a capture register, so a debugger can save the pointer and restore it later. A match read compares a tag against the whole segment and returns the selected word of the matching line, with a hit flag.

Commands arrive as single-cycle strobes. Read results come back on the next cycle with a valid flag. The tag and data arrays are held inside the block as register arrays.

Top module: `cache_victim_ctl`

## Requirements
- R1: After reset, every segment's pointer is 0 and every segment is in plain mode. `dbg_victim` is 0, `rsp_vld` is low, and every tag entry is invalid with a zero tag.
- R2: Opcodes 0 (lockdown-base write) and 1 (plain write) load the pointer of segment `cmd_arg[6:5]` with `cmd_arg[31:26]`. All other operand bits are ignored.
- R3: After an opcode 0 write, the segment's pointer advances by one after each tag read (2), tag write (3), data read (4) and data write (5) to that segment.
- R4: After an opcode 1 write, the segment's pointer advances after tag reads and tag writes only. Data reads and data writes leave it unchanged.
- R5: When the pointer advances from the last line (63), it wraps to 0.
- R6: Each segment keeps its own mode, taken from the most recent pointer write to that segment.
- R7: A tag read (2) returns `{valid, 7'b0, tag[23:0]}` of line `pointer` in the addressed segment. On the same edge it loads `dbg_victim` with the pointer value from before the advance. No other command changes `dbg_victim`.
- R8: A tag write (3) stores `valid = cmd_wdata[31]` and `tag = cmd_wdata[23:0]` into line `pointer`.
- R9: A data write (5) stores `cmd_wdata` into word `cmd_arg[3:2]` of line `pointer`. A data read (4) returns that 32-bit word.
- R10: A match read (6) looks for valid entries in the addressed segment whose tag equals `cmd_wdata[23:0]`. On a hit it returns bit 31 = 1, bit 30 = 0, and bits [29:0] = word `cmd_arg[3:2]` of the lowest-numbered matching line. A miss returns all zeros. The pointer does not move.
- R11: `rsp_vld` rises exactly one cycle after each read command (2, 4, 6) and at no other time. Opcode 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_vld | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 3 | Command opcode |
| cmd_arg | input | 32 | Operand: index [31:26], segment [6:5], word [3:2] |
| cmd_wdata | input | 32 | Write data, or compare tag for a match read |
| rsp_vld | output | 1 | Read result valid |
| rsp_data | output | 32 | Read result |
| dbg_victim | output | 6 | Pointer captured by the most recent tag read |

## Verification
The assertions check on every cycle that responses follow read commands exactly one cycle later. They also check that the pointer steps with wrap after tag accesses, and after data accesses only in lockdown-base mode. Further cycle-level checks cover the capture register loading only on tag reads, and match reads never moving the pointer. Only the bench scenarios can show that the returned data is correct: the lowest line winning among duplicate tags, invalid entries never matching, segments keeping independent modes, and a full 64-line walk that comes back around to line 0.

// File: rtl/cache_victim_ctl.sv
module cache_victim_ctl #(
  parameter int NSEG  = 4,
  parameter int NLINE = 64,
  parameter int NWORD = 4,
  parameter int TW    = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_vld,
  input  logic [2:0]  cmd_op,
  input  logic [31:0] cmd_arg,
  input  logic [31:0] cmd_wdata,
  output logic        rsp_vld,
  output logic [31:0] rsp_data,
  output logic [$clog2(NLINE)-1:0] dbg_victim
);
  localparam int SW = $clog2(NSEG);
  localparam int IW = $clog2(NLINE);
  localparam int WW = $clog2(NWORD);

  localparam logic [2:0] OP_VLOCK = 3'd0, OP_VPLAIN = 3'd1, OP_CRD = 3'd2, OP_CWR = 3'd3,
                         OP_RRD = 3'd4, OP_RWR = 3'd5, OP_MRD = 3'd6;

  logic [NSEG-1:0][IW-1:0] vptr;
  logic [NSEG-1:0]         lock_mode;
  logic                    cam_v   [NSEG][NLINE];
  logic [TW-1:0]           cam_tag [NSEG][NLINE];
  logic [31:0]             ram     [NSEG][NLINE][NWORD];

  wire [SW-1:0] seg  = cmd_arg[5+SW-1:5];
  wire [WW-1:0] wsel = cmd_arg[2+WW-1:2];
  wire [IW-1:0] vidx = cmd_arg[31:32-IW];
  wire [IW-1:0] cur  = vptr[seg];
  wire [IW-1:0] nxt  = (cur == IW'(NLINE-1)) ? '0 : cur + 1'b1;

  wire is_vwr = cmd_vld && (cmd_op == OP_VLOCK || cmd_op == OP_VPLAIN);
  wire is_cam = cmd_vld && (cmd_op == OP_CRD || cmd_op == OP_CWR);
  wire is_ram = cmd_vld && (cmd_op == OP_RRD || cmd_op == OP_RWR);
  wire is_rd  = cmd_vld && (cmd_op == OP_CRD || cmd_op == OP_RRD || cmd_op == OP_MRD);
  wire bump   = is_cam || (is_ram && lock_mode[seg]);

  logic          hit;
  logic [IW-1:0] hidx;
  always_comb begin
    hit  = 1'b0;
    hidx = '0;
    for (int i = NLINE-1; i >= 0; i--)
      if (cam_v[seg][i] && cam_tag[seg][i] == cmd_wdata[TW-1:0]) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (cmd_op)
      OP_CRD:  rd_mux = {cam_v[seg][cur], {(31-TW){1'b0}}, cam_tag[seg][cur]};
      OP_RRD:  rd_mux = ram[seg][cur][wsel];
      OP_MRD:  rd_mux = hit ? {2'b10, ram[seg][hidx][wsel][29:0]} : '0;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vptr       <= '0;
      lock_mode  <= '0;
      dbg_victim <= '0;
      rsp_vld    <= 1'b0;
      rsp_data   <= '0;
    end else begin
      rsp_vld <= is_rd;
      if (is_rd) rsp_data <= rd_mux;
      if (is_vwr) begin
        vptr[seg]      <= vidx;
        lock_mode[seg] <= (cmd_op == OP_VLOCK);
      end else if (bump) begin
        vptr[seg] <= nxt;
      end
      if (cmd_vld && cmd_op == OP_CRD) dbg_victim <= cur;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NSEG; s++)
        for (int l = 0; l < NLINE; l++) begin
          cam_v[s][l]   <= 1'b0;
          cam_tag[s][l] <= '0;
        end
    end else if (cmd_vld && cmd_op == OP_CWR) begin
      cam_v[seg][cur]   <= cmd_wdata[31];
      cam_tag[seg][cur] <= cmd_wdata[TW-1:0];
    end
  end

  always_ff @(posedge clk)
    if (cmd_vld && cmd_op == OP_RWR) ram[seg][cur][wsel] <= cmd_wdata;

endmodule

// File: rtl/cache_victim_ctl_chk.sv
module cache_victim_ctl_chk #(
  parameter int NSEG  = 4,
  parameter int NLINE = 64
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          cmd_vld,
  input logic [2:0]                    cmd_op,
  input logic [31:0]                   cmd_arg,
  input logic                          rsp_vld,
  input logic [31:0]                   rsp_data,
  input logic [$clog2(NLINE)-1:0]      dbg_victim,
  input logic [NSEG-1:0][$clog2(NLINE)-1:0] vptr,
  input logic [NSEG-1:0]               lock_mode
);
  localparam int SW = $clog2(NSEG);
  localparam int IW = $clog2(NLINE);

  wire [SW-1:0] seg  = cmd_arg[5+SW-1:5];
  wire c_cam  = cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd3);
  wire c_ram  = cmd_vld && (cmd_op == 3'd4 || cmd_op == 3'd5);
  wire c_rd   = cmd_vld && (cmd_op == 3'd2 || cmd_op == 3'd4 || cmd_op == 3'd6);
  wire c_crd  = cmd_vld && cmd_op == 3'd2;
  wire c_mrd  = cmd_vld && cmd_op == 3'd6;

  logic [SW-1:0] seg_q;
  logic [IW-1:0] cur_q, inc_q;
  logic          rd_q, mrd_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0; cur_q <= '0; inc_q <= '0; rd_q <= 1'b0; mrd_q <= 1'b0;
    end else begin
      seg_q <= seg;
      cur_q <= vptr[seg];
      inc_q <= (vptr[seg] == IW'(NLINE-1)) ? '0 : vptr[seg] + 1'b1;
      rd_q  <= c_rd;
      mrd_q <= c_mrd;
    end
  end

  AST_RSP_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> rd_q);                                                       // R11
  AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    c_rd |=> rsp_vld);                                                       // R11
  AST_CAM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    c_cam |=> vptr[seg_q] == inc_q);                                         // R5
  AST_LOCK_RAM_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ram && lock_mode[seg]) |=> vptr[seg_q] == inc_q);                     // R3
  AST_PLAIN_RAM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ram && !lock_mode[seg]) |=> $stable(vptr));                           // R4
  AST_DBG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    c_crd |=> dbg_victim == cur_q);                                          // R7
  AST_DBG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !c_crd |=> $stable(dbg_victim));                                         // R7
  AST_MATCH_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    c_mrd |=> $stable(vptr));                                                // R10
  AST_MATCH_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && mrd_q) |-> (!rsp_data[30] && (rsp_data[31] || rsp_data == '0))); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> ($stable(vptr) && $stable(lock_mode)));                     // R11
endmodule

bind cache_victim_ctl cache_victim_ctl_chk #(.NSEG(NSEG), .NLINE(NLINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
  .rsp_vld(rsp_vld), .rsp_data(rsp_data), .dbg_victim(dbg_victim),
  .vptr(vptr), .lock_mode(lock_mode)
);

// File: tb/cache_victim_ctl_tb.sv
`timescale 1ns/1ps
module cache_victim_ctl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_vld = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [31:0] cmd_arg = '0, cmd_wdata = '0;
  logic rsp_vld;
  logic [31:0] rsp_data;
  logic [5:0] dbg_victim;

  cache_victim_ctl u_dut (.clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_arg(cmd_arg), .cmd_wdata(cmd_wdata), .rsp_vld(rsp_vld), .rsp_data(rsp_data),
    .dbg_victim(dbg_victim));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 1'b0, live = 1'b0;
  logic [31:0] exp_q[$];
  string       req_q[$];

  logic [5:0]  m_ptr [4];
  bit          m_lock[4];
  bit          m_cv  [4][64];
  logic [23:0] m_tag [4][64];
  logic [31:0] m_ram [4][64][4];
  logic [5:0]  m_dbg;

  function automatic logic [31:0] va(input logic [5:0] idx, input int s);
    return {idx, 19'h5A5A5, 2'(s), 5'h1B};
  endfunction
  function automatic logic [31:0] aa(input int s, input int w);
    return {25'h0, 2'(s), 1'b0, 2'(w), 2'b11};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string rq);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic [31:0] arg, input logic [31:0] wd,
                      input string rq);
    int s, w;
    bit adv, rd, h;
    logic [31:0] e;
    s = int'(arg[6:5]); w = int'(arg[3:2]);
    adv = 1'b0; rd = 1'b0; e = '0;
    cmd_vld = 1'b1; cmd_op = op; cmd_arg = arg; cmd_wdata = wd;
    case (op)
      3'd0, 3'd1: begin m_ptr[s] = arg[31:26]; m_lock[s] = (op == 3'd0); end
      3'd2: begin rd = 1; e = {m_cv[s][m_ptr[s]], 7'b0, m_tag[s][m_ptr[s]]}; m_dbg = m_ptr[s]; adv = 1; end
      3'd3: begin m_cv[s][m_ptr[s]] = wd[31]; m_tag[s][m_ptr[s]] = wd[23:0]; adv = 1; end
      3'd4: begin rd = 1; e = m_ram[s][m_ptr[s]][w]; adv = m_lock[s]; end
      3'd5: begin m_ram[s][m_ptr[s]][w] = wd; adv = m_lock[s]; end
      3'd6: begin
        rd = 1; h = 0;
        for (int i = 0; i < 64; i++)
          if (!h && m_cv[s][i] && m_tag[s][i] == wd[23:0]) begin
            h = 1; e = {2'b10, m_ram[s][i][w][29:0]};
          end
      end
      default: ;
    endcase
    if (adv) m_ptr[s] = (m_ptr[s] == 6'd63) ? 6'd0 : m_ptr[s] + 6'd1;
    @(posedge clk);
    if (rd) begin exp_q.push_back(e); req_q.push_back(rq); end
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  always @(negedge clk) begin
    if (live) begin
      if (rsp_vld) begin
        if (exp_q.size() == 0) chk(1'b1, 1'b0, "R11 unexpected rsp_vld");
        else chk(rsp_data, exp_q.pop_front(), req_q.pop_front());
      end else if (exp_q.size() != 0) begin
        chk(1'b0, 1'b1, "R11 missing rsp_vld");
        void'(exp_q.pop_front()); void'(req_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_ptr[s] = '0; m_lock[s] = 0;
      for (int l = 0; l < 64; l++) begin m_cv[s][l] = 0; m_tag[s][l] = '0; end
    end
    m_dbg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    live = 1'b1;
    chk(rsp_vld, 0, "R1 rsp_vld after reset");
    chk(dbg_victim, 0, "R1 dbg_victim after reset");
    send(3'd2, aa(0, 0), 0, "R1 tag read after reset");
    chk(dbg_victim, 0, "R1 pointer zero after reset");

    send(3'd1, va(6'd10, 1), 0, "R2");
    send(3'd2, aa(1, 0), 0, "R2 read");
    chk(dbg_victim, 10, "R2 index field loads pointer");

    send(3'd0, va(6'd5, 2), 0, "R3");
    send(3'd5, aa(2, 0), 32'hDEAD_0001, "R9 write");
    send(3'd5, aa(2, 1), 32'hBEEF_0002, "R9 write");
    send(3'd0, va(6'd5, 2), 0, "R3");
    send(3'd4, aa(2, 0), 0, "R9 data read line5");
    send(3'd4, aa(2, 1), 0, "R3 data read advanced to line6");
    send(3'd2, aa(2, 0), 0, "R3 read");
    chk(dbg_victim, 7, "R3 pointer after data accesses");

    send(3'd1, va(6'd62, 3), 0, "R4");
    for (int w = 0; w < 4; w++) send(3'd5, aa(3, w), 32'h1000_0000 + w, "R4 write");
    send(3'd4, aa(3, 2), 0, "R4 data read same line");
    send(3'd2, aa(3, 0), 0, "R4 read");
    chk(dbg_victim, 62, "R4 data accesses hold pointer");
    send(3'd3, aa(3, 0), 32'h8012_3456, "R8 write line63");
    send(3'd2, aa(3, 0), 0, "R5 read after wrap");
    chk(dbg_victim, 0, "R5 wrap 63 to 0");
    send(3'd1, va(6'd63, 3), 0, "R8");
    send(3'd2, aa(3, 0), 0, "R8 tag read back line63");

    send(3'd0, va(6'd20, 0), 0, "R6");
    send(3'd1, va(6'd20, 1), 0, "R6");
    send(3'd5, aa(0, 0), 32'h1, "R6 write");
    send(3'd5, aa(1, 0), 32'h2, "R6 write");
    send(3'd2, aa(0, 0), 0, "R6 read");
    chk(dbg_victim, 21, "R6 lock segment advanced");
    send(3'd2, aa(1, 0), 0, "R6 read");
    chk(dbg_victim, 20, "R6 plain segment held");

    send(3'd1, va(6'd0, 3), 0, "R10");
    send(3'd3, aa(3, 0), 32'h80AB_CDEF, "R10 tag");
    send(3'd3, aa(3, 0), 32'h80AB_CDEF, "R10 dup tag");
    send(3'd3, aa(3, 0), 32'h0011_2233, "R10 invalid tag");
    send(3'd1, va(6'd0, 3), 0, "R10");
    send(3'd5, aa(3, 1), 32'hFFFF_0A0A, "R10 data");
    send(3'd1, va(6'd1, 3), 0, "R10");
    send(3'd5, aa(3, 1), 32'h1234_5678, "R10 data");
    send(3'd6, aa(3, 1), 32'h00AB_CDEF, "R10 hit lowest line");
    send(3'd6, aa(3, 1), 32'h0011_2233, "R10 invalid never hits");
    send(3'd6, aa(3, 1), 32'h0077_7777, "R10 miss zero");
    send(3'd2, aa(3, 0), 0, "R10 read");
    chk(dbg_victim, 1, "R10 match keeps pointer");

    send(3'd7, va(6'd40, 3), 32'hFFFF_FFFF, "R11");
    chk(rsp_vld, 0, "R11 opcode7 no response");
    send(3'd2, aa(3, 0), 0, "R11 read");
    chk(dbg_victim, 2, "R11 opcode7 left pointer");

    send(3'd0, va(6'd0, 0), 0, "R5");
    for (int i = 0; i < 64; i++) send(3'd3, aa(0, 0), {1'b1, 7'b0, 24'(i * 3 + 7)}, "R5 walk write");
    for (int i = 0; i < 64; i++) send(3'd2, aa(0, 0), 0, "R5 walk read");
    chk(dbg_victim, 63, "R5 walk last line");
    send(3'd2, aa(0, 0), 0, "R5 walk wrapped read");
    chk(dbg_victim, 0, "R5 walk back to 0");

    repeat (2) @(negedge clk);
    chk(exp_q.size(), 0, "R11 all responses seen");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule